// File: doc/BRIEF.md
# Interrupt Request Controller

This block collects interrupt events from the on-chip peripherals and one external pin, latches each one into its own request flag, and offers the CPU a single prioritised request as a valid bit and a 3-bit vector index. Three down-counting timers, a clocked serial shift port, a byte-completion event from an I2C engine, an external pin with a programmable edge direction, and a software break strobe are the sources. Every source has its own trigger rule. The block only decides when each event counts. The timer reload logic, the serial data path and the I2C protocol engine sit outside it and report their state through plain level and strobe inputs.

Every source except break has an enable bit. A global disable input, taken from the CPU's interrupt-disable flag, masks all of those sources together. A flag stays latched while it is masked, so software can read the pending flags at any time. The CPU takes the presented vector and acknowledges that index, which clears the flag. Software can also clear any group of flags with a mask write.

Vector indices, from highest to lowest priority: 0 timer 3, 1 timer 2, 2 timer 1, 3 serial, 4 I2C, 5 external pin, 6 break. Bit k of `reqFlags`, `clrMask` and `enData` belongs to vector k. `enData` has no bit for break. `tmrTick[0]`, `tmrTick[1]` and `tmrTick[2]` belong to timers 1, 2 and 3.

Top module: `intreq_unit`

## Requirements
- R1: A timer flag sets on the clock edge that samples `tmrTick` high while `tmrZero` is high for that timer. A tick with `tmrZero` low sets nothing, and `tmrZero` high without a tick sets nothing.
- R2: The serial flag sets on the eighth rising edge of `serClk` counted after a `serDataWr` strobe. Another write before the eighth edge restarts the count from zero.
- R3: After the eighth edge, further `serClk` edges set nothing until the next `serDataWr`. After reset the counter is idle, so edges with no prior write set nothing.
- R4: The I2C flag sets when `sclIn` falls while `i2cByteDone` is high. A rising SCL edge, or a falling edge while `i2cByteDone` is low, sets nothing.
- R5: `extPin` passes through a two-stage synchronizer before edge detection. With polarity 0 a low-to-high transition sets flag 5, and with polarity 1 a high-to-low transition does. The flag is visible after the third clock edge following the pin change. A transition in the other direction sets nothing.
- R6: A polarity write (`polWr` with `polData`) while the pin is steady never sets flag 5.
- R7: A flag stays set until an acknowledge of its index or a `clrWr` with its `clrMask` bit set. If a set event and a clear fall in the same cycle, the flag ends up set.
- R8: A source at vector 0 to 5 is eligible for arbitration only when its enable bit is 1 and `intDisable` is 0. Its flag latches whether or not it is eligible.
- R9: `irqValid` is high when at least one eligible flag exists, and `irqIdx` is the lowest eligible index. When `irqValid` is low, `irqIdx` is 0.
- R10: The break flag (vector 6) is always eligible, whatever the enable bits and `intDisable` are, and it is granted only when no other eligible flag exists.
- R11: Reset clears all flags, all enable bits and the polarity bit (polarity 0), and leaves the serial counter idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrTick | input | 3 | Count-source pulse per timer, bit 0 = timer 1 |
| tmrZero | input | 3 | Timer value is currently zero, bit 0 = timer 1 |
| serClk | input | 1 | Serial transfer clock level, sampled by clk |
| serDataWr | input | 1 | Strobe: software wrote the serial data register |
| sclIn | input | 1 | I2C SCL level, sampled by clk |
| i2cByteDone | input | 1 | I2C engine reports that a byte transfer is ending |
| extPin | input | 1 | External interrupt pin, asynchronous |
| polWr | input | 1 | Strobe: write the pin polarity bit |
| polData | input | 1 | New polarity: 0 low-to-high, 1 high-to-low |
| brkExec | input | 1 | Strobe: CPU executed the break instruction |
| intDisable | input | 1 | Global disable flag for maskable sources |
| enWr | input | 1 | Strobe: write the enable bits |
| enData | input | 6 | Enable bits for vectors 0 to 5 |
| clrWr | input | 1 | Strobe: clear the flags selected by clrMask |
| clrMask | input | 7 | Flags to clear, bit k = vector k |
| ackValid | input | 1 | Strobe: CPU acknowledges vector ackIdx |
| ackIdx | input | 3 | Acknowledged vector index |
| irqValid | output | 1 | An eligible request is pending |
| irqIdx | output | 3 | Winning vector index |
| reqFlags | output | 7 | Latched request flags, bit k = vector k |

## Verification
The hardest state to reach from the ports is a chosen mix of pending flags. The serial flag needs a write followed by eight clock edges, and the pin flag needs a polarity setup and three cycles of synchronizer delay. The bench builds each of the 128 flag combinations from real source events, without a direct set path. With each combination held, it sweeps all 64 enable patterns under both values of the global disable, so every priority and masking case meets the arbiter. Separate sequences cover the serial restart and the idle counter after the eighth edge, a polarity write with a steady pin, and a set event in the same cycle as a clear.

// File: rtl/intreq_pkg.sv
package intreq_pkg;

  localparam int NUM_TIMERS = 3;
  localparam int NUM_SRC    = NUM_TIMERS + 4;
  localparam int NUM_MASK   = NUM_SRC - 1;
  localparam int IDX_W      = $clog2(NUM_SRC);

  localparam int SER_IDX = NUM_TIMERS;
  localparam int I2C_IDX = NUM_TIMERS + 1;
  localparam int PIN_IDX = NUM_TIMERS + 2;
  localparam int BRK_IDX = NUM_TIMERS + 3;

  // One-cycle event strobes, passed from control to datapath
  typedef struct packed {
    logic [NUM_TIMERS-1:0] timer;  // bit 0 = timer 1
    logic                  serial;
    logic                  i2c;
    logic                  pin;
    logic                  brk;
  } evtStrobes_t;

endpackage

// File: rtl/intreq_ctrl.sv
module intreq_ctrl
  import intreq_pkg::*;
#(
  parameter int SER_EDGES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TIMERS-1:0] tmrTick,
  input  logic [NUM_TIMERS-1:0] tmrZero,
  input  logic                  serClk,
  input  logic                  serDataWr,
  input  logic                  sclIn,
  input  logic                  i2cByteDone,
  input  logic                  extPin,
  input  logic                  polWr,
  input  logic                  polData,
  input  logic                  brkExec,
  output evtStrobes_t           evt
);

  localparam int CNT_W = $clog2(SER_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(SER_EDGES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SER_EDGES - 1);

  // ---------------- timers ----------------
  logic [NUM_TIMERS-1:0] tmrHit;
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    assign tmrHit[t] = tmrTick[t] & tmrZero[t];
  end

  // ---------------- serial edge counter ----------------
  logic             serClkQ;
  logic [CNT_W-1:0] serCnt;
  logic             serRise;
  logic             serHit;

  assign serRise = serClk & ~serClkQ;
  assign serHit  = serRise & ~serDataWr & (serCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      serCnt  <= CNT_IDLE;
    end else begin
      serClkQ <= serClk;
      if (serDataWr)
        serCnt <= '0;
      else if (serRise && serCnt != CNT_IDLE)
        serCnt <= serCnt + 1'b1;
    end
  end

  // ---------------- I2C byte completion ----------------
  logic sclQ;
  logic i2cHit;

  assign i2cHit = sclQ & ~sclIn & i2cByteDone;

  always_ff @(posedge clk) begin
    if (!rstN) sclQ <= 1'b1;
    else       sclQ <= sclIn;
  end

  // ---------------- external pin ----------------
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinLvl;
  logic                   polQ;
  logic                   normPrev;
  logic                   normNow;
  logic                   pinHit;

  assign pinLvl  = syncQ[SYNC_STAGES-1];
  assign normNow = pinLvl ^ polQ;
  assign pinHit  = normNow & ~normPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      polQ     <= 1'b0;
      normPrev <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      if (polWr) begin
        polQ     <= polData;
        normPrev <= pinLvl ^ polData;  // reload: no false edge from a polarity change
      end else begin
        normPrev <= normNow;
      end
    end
  end

  always_comb begin
    evt.timer  = tmrHit;
    evt.serial = serHit;
    evt.i2c    = i2cHit;
    evt.pin    = pinHit;
    evt.brk    = brkExec;
  end

  // ---------------- assertions ----------------
  assert_ser_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    serCnt <= CNT_IDLE);
  assert_ser_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (serCnt == CNT_IDLE) |-> !evt.serial);
  assert_ser_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    evt.serial |=> (serCnt == CNT_IDLE));
  assert_ser_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    serDataWr |=> (serCnt == '0));
  assert_pol_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    polWr |=> (!evt.pin || (pinLvl != $past(pinLvl))));

endmodule

// File: rtl/intreq_dp.sv
module intreq_dp
  import intreq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  evtStrobes_t         evt,
  input  logic                intDisable,
  input  logic                enWr,
  input  logic [NUM_MASK-1:0] enData,
  input  logic                clrWr,
  input  logic [NUM_SRC-1:0]  clrMask,
  input  logic                ackValid,
  input  logic [IDX_W-1:0]    ackIdx,
  output logic                irqValid,
  output logic [IDX_W-1:0]    irqIdx,
  output logic [NUM_SRC-1:0]  reqFlags
);

  logic [NUM_SRC-1:0]  setVec;
  logic [NUM_SRC-1:0]  ackVec;
  logic [NUM_SRC-1:0]  clrVec;
  logic [NUM_SRC-1:0]  flags;
  logic [NUM_MASK-1:0] enQ;
  logic [NUM_SRC-1:0]  eligible;

  // Timer 3 takes vector 0, so the timer order is reversed here
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmrMap
    assign setVec[i] = evt.timer[NUM_TIMERS-1-i];
  end
  assign setVec[SER_IDX] = evt.serial;
  assign setVec[I2C_IDX] = evt.i2c;
  assign setVec[PIN_IDX] = evt.pin;
  assign setVec[BRK_IDX] = evt.brk;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ackVec[i] = ackValid && (ackIdx == IDX_W'(i));
  end

  assign clrVec = (clrWr ? clrMask : '0) | ackVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
      enQ   <= '0;
    end else begin
      flags <= (flags & ~clrVec) | setVec;
      if (enWr) enQ <= enData;
    end
  end

  assign eligible = flags & {1'b1, (intDisable ? '0 : enQ)};

  always_comb begin
    irqValid = 1'b0;
    irqIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        irqValid = 1'b1;
        irqIdx   = IDX_W'(i);
      end
    end
  end

  assign reqFlags = flags;

  // ---------------- assertions ----------------
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((flags & $past(setVec)) == $past(setVec)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags & ~clrVec)) |=> ((flags & $past(flags & ~clrVec)) == $past(flags & ~clrVec)));
  assert_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> eligible[irqIdx]);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> ((irqIdx == '0) && (flags[BRK_IDX] == 1'b0)));
  assert_brk_R10: assert property (@(posedge clk) disable iff (!rstN)
    flags[BRK_IDX] |-> irqValid);
  assert_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intDisable && irqValid) |-> (irqIdx == IDX_W'(BRK_IDX)));

endmodule

// File: rtl/intreq_unit.sv
module intreq_unit
  import intreq_pkg::*;
#(
  parameter int SER_EDGES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TIMERS-1:0] tmrTick,
  input  logic [NUM_TIMERS-1:0] tmrZero,
  input  logic                  serClk,
  input  logic                  serDataWr,
  input  logic                  sclIn,
  input  logic                  i2cByteDone,
  input  logic                  extPin,
  input  logic                  polWr,
  input  logic                  polData,
  input  logic                  brkExec,
  input  logic                  intDisable,
  input  logic                  enWr,
  input  logic [NUM_MASK-1:0]   enData,
  input  logic                  clrWr,
  input  logic [NUM_SRC-1:0]    clrMask,
  input  logic                  ackValid,
  input  logic [IDX_W-1:0]      ackIdx,
  output logic                  irqValid,
  output logic [IDX_W-1:0]      irqIdx,
  output logic [NUM_SRC-1:0]    reqFlags
);

  evtStrobes_t evt;

  intreq_ctrl #(
    .SER_EDGES  (SER_EDGES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tmrTick    (tmrTick),
    .tmrZero    (tmrZero),
    .serClk     (serClk),
    .serDataWr  (serDataWr),
    .sclIn      (sclIn),
    .i2cByteDone(i2cByteDone),
    .extPin     (extPin),
    .polWr      (polWr),
    .polData    (polData),
    .brkExec    (brkExec),
    .evt        (evt)
  );

  intreq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .intDisable(intDisable),
    .enWr      (enWr),
    .enData    (enData),
    .clrWr     (clrWr),
    .clrMask   (clrMask),
    .ackValid  (ackValid),
    .ackIdx    (ackIdx),
    .irqValid  (irqValid),
    .irqIdx    (irqIdx),
    .reqFlags  (reqFlags)
  );

endmodule

// File: tb/intreq_unit_bench.sv
`timescale 1ns/1ps
module intreq_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] tmrTick = '0;
  logic [2:0] tmrZero = '0;
  logic       serClk = 1'b0;
  logic       serDataWr = 1'b0;
  logic       sclIn = 1'b1;
  logic       i2cByteDone = 1'b0;
  logic       extPin = 1'b0;
  logic       polWr = 1'b0;
  logic       polData = 1'b0;
  logic       brkExec = 1'b0;
  logic       intDisable = 1'b0;
  logic       enWr = 1'b0;
  logic [5:0] enData = '0;
  logic       clrWr = 1'b0;
  logic [6:0] clrMask = '0;
  logic       ackValid = 1'b0;
  logic [2:0] ackIdx = '0;
  logic       irqValid;
  logic [2:0] irqIdx;
  logic [6:0] reqFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intreq_unit u_intreq_unit (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .tmrZero(tmrZero),
    .serClk(serClk), .serDataWr(serDataWr), .sclIn(sclIn),
    .i2cByteDone(i2cByteDone), .extPin(extPin), .polWr(polWr),
    .polData(polData), .brkExec(brkExec), .intDisable(intDisable),
    .enWr(enWr), .enData(enData), .clrWr(clrWr), .clrMask(clrMask),
    .ackValid(ackValid), .ackIdx(ackIdx), .irqValid(irqValid),
    .irqIdx(irqIdx), .reqFlags(reqFlags)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    clrWr = 1'b1; clrMask = '1; step(1);
    clrWr = 1'b0; clrMask = '0;
  endtask

  task automatic serEdge();
    serClk = 1'b1; step(1);
    serClk = 1'b0; step(1);
  endtask

  task automatic writeEn(input logic [5:0] v);
    enWr = 1'b1; enData = v; step(1);
    enWr = 1'b0;
  endtask

  task automatic writePol(input logic v);
    polWr = 1'b1; polData = v; step(1);
    polWr = 1'b0;
  endtask

  // Build the flag pattern pat from real source events
  task automatic makePattern(input logic [6:0] pat);
    clearAll();
    tmrZero = '1;
    tmrTick = {pat[0], pat[1], pat[2]};
    brkExec = pat[6];
    step(1);
    tmrTick = '0; brkExec = 1'b0; tmrZero = '0;
    if (pat[3]) begin
      serDataWr = 1'b1; step(1); serDataWr = 1'b0;
      repeat (8) serEdge();
    end
    if (pat[4]) begin
      i2cByteDone = 1'b1; sclIn = 1'b0; step(1);
      sclIn = 1'b1; i2cByteDone = 1'b0; step(1);
    end
    if (pat[5]) begin
      writePol(extPin);
      step(1);
      extPin = ~extPin;
      step(3);
    end
  endtask

  function automatic int expectGrant(input logic [6:0] pat, input logic [5:0] en,
                                     input logic dis);
    logic [6:0] elig;
    elig = pat & {1'b1, (dis ? 6'b0 : en)};
    for (int k = 0; k < 7; k++)
      if (elig[k]) return 8 | k;
    return 0;
  endfunction

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);

    // R11: reset state
    check("R11 flags after reset", reqFlags, 0);
    check("R11 irqValid after reset", irqValid, 0);
    check("R11 irqIdx after reset", irqIdx, 0);
    // R11/R3: serial counter idle after reset
    repeat (10) serEdge();
    check("R3 R11 serial idle after reset", reqFlags[3], 0);
    // R11: polarity 0 after reset, rising edge detected
    extPin = 1'b1; step(2);
    check("R5 pin not yet after two edges", reqFlags[5], 0);
    step(1);
    check("R5 R11 rising edge with reset polarity", reqFlags[5], 1);
    // R11: enables cleared, so no grant though flag set
    check("R11 R8 enables reset", irqValid, 0);
    extPin = 1'b0; step(4);
    check("R5 falling edge ignored at polarity 0", reqFlags, 7'h20);
    clearAll();

    // R1: timer trigger combinations
    for (int t = 0; t < 3; t++) begin
      for (int c = 0; c < 4; c++) begin
        clearAll();
        tmrTick[t] = c[0]; tmrZero[t] = c[1];
        step(1);
        tmrTick = '0; tmrZero = '0;
        check("R1 timer trigger", reqFlags, (c == 3) ? (1 << (2 - t)) : 0);
      end
    end

    // R2: eighth edge sets, seventh does not
    clearAll();
    serDataWr = 1'b1; step(1); serDataWr = 1'b0;
    repeat (7) serEdge();
    check("R2 seven edges", reqFlags[3], 0);
    serEdge();
    check("R2 eighth edge", reqFlags[3], 1);
    // R3: no further requests until next write
    clearAll();
    repeat (16) serEdge();
    check("R3 edges after eighth ignored", reqFlags[3], 0);
    // R2: restart on write mid-count
    serDataWr = 1'b1; step(1); serDataWr = 1'b0;
    repeat (5) serEdge();
    serDataWr = 1'b1; step(1); serDataWr = 1'b0;
    repeat (7) serEdge();
    check("R2 restart keeps count below eight", reqFlags[3], 0);
    serEdge();
    check("R2 eighth after restart", reqFlags[3], 1);
    clearAll();

    // R4: I2C edge rules
    i2cByteDone = 1'b0; sclIn = 1'b0; step(1); sclIn = 1'b1; step(1);
    check("R4 fall without byte end", reqFlags[4], 0);
    sclIn = 1'b0; step(1); i2cByteDone = 1'b1; sclIn = 1'b1; step(1);
    check("R4 rising edge ignored", reqFlags[4], 0);
    sclIn = 1'b0; step(1); sclIn = 1'b1; i2cByteDone = 1'b0; step(1);
    check("R4 falling edge at byte end", reqFlags[4], 1);
    clearAll();

    // R5: polarity 1 detects falling edge only
    writePol(1'b1); step(1);
    extPin = 1'b1; step(4);
    check("R5 rising ignored at polarity 1", reqFlags[5], 0);
    extPin = 1'b0; step(2);
    check("R5 falling not yet after two edges", reqFlags[5], 0);
    step(1);
    check("R5 falling detected at polarity 1", reqFlags[5], 1);
    clearAll();

    // R6: polarity writes with a steady pin
    for (int w = 0; w < 4; w++) begin
      writePol(w[0]); step(3);
      check("R6 polarity write no request", reqFlags[5], 0);
    end
    extPin = 1'b1; step(4);
    for (int w = 0; w < 4; w++) begin
      writePol(~w[0]); step(3);
      check("R6 polarity write high pin no request", reqFlags[5], 0);
    end
    writePol(1'b0);
    extPin = 1'b0; step(4);
    clearAll();

    // R7: set wins over clear in same cycle
    tmrZero = 3'b001; tmrTick = 3'b001; clrWr = 1'b1; clrMask = 7'h04;
    step(1);
    tmrZero = '0; tmrTick = '0; clrWr = 1'b0; clrMask = '0;
    check("R7 set beats software clear", reqFlags, 7'h04);
    brkExec = 1'b1; ackValid = 1'b1; ackIdx = 3'd6; step(1);
    brkExec = 1'b0; ackValid = 1'b0;
    check("R7 set beats acknowledge", reqFlags, 7'h44);
    step(5);
    check("R7 flags held", reqFlags, 7'h44);
    // R10: break granted with enables off
    check("R10 break granted unmasked", {irqValid, irqIdx}, 8 | 6);
    intDisable = 1'b1; step(1);
    check("R10 break ignores disable", {irqValid, irqIdx}, 8 | 6);
    intDisable = 1'b0;
    clrWr = 1'b1; clrMask = 7'h04; step(1); clrWr = 1'b0;
    check("R7 software clear one flag", reqFlags, 7'h40);

    // R8 R9 R10: sweep every flag pattern, enable pattern and disable value
    for (int p = 0; p < 128; p++) begin
      makePattern(7'(p));
      check("R7 R5 pattern built", reqFlags, p);
      for (int e = 0; e < 64; e++) begin
        writeEn(6'(e));
        intDisable = 1'b0; step(1);
        check("R9 R8 grant enabled", {irqValid, irqIdx}, expectGrant(7'(p), 6'(e), 1'b0));
        intDisable = 1'b1; step(1);
        check("R8 R10 grant disabled", {irqValid, irqIdx}, expectGrant(7'(p), 6'(e), 1'b1));
      end
      intDisable = 1'b0;
      check("R8 flags latched while masked", reqFlags, p);
    end

    // R7 R9: acknowledge in priority order
    makePattern(7'h7f);
    writeEn(6'h3f);
    for (int k = 0; k < 7; k++) begin
      check("R9 acknowledge order", {irqValid, irqIdx}, 8 | k);
      ackValid = 1'b1; ackIdx = irqIdx; step(1);
      ackValid = 1'b0;
      check("R7 acknowledge clears flag", reqFlags, 7'h7f & ~((2 << k) - 1));
    end
    check("R9 idle after all acks", {irqValid, irqIdx}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule